// File: doc/BRIEF.md
# Quadrature Pulse Counter Unit

This block counts edges on two independent pulse channels into one signed 16-bit total. Each channel has a pulse pin and a control pin. A rising or a falling pulse edge can add one, subtract one or do nothing. The level of the channel's control pin can then pass that choice through unchanged, swap the direction, or block it. Wiring an encoder's A and B phases to the pulse and control pins of the two channels, in crossed fashion, gives a quadrature decoder. A single channel can also serve as a plain up or down event counter.

Every pin passes through a two-stage synchroniser and an optional glitch filter before edge detection. The running total is compared with an upper limit, a lower limit, two programmable match values and zero. Each comparison is a watch event with its own enable. Reaching an enabled limit returns the total to zero. Crossing zero records the direction of the crossing. Every event sets one shared interrupt flag, which software clears by writing a one. Pause, clear, the filter settings and all action selections are static, register-style inputs.

Top module: `quad_pulse_counter`

## Requirements
- R1: After a synchronous active-low reset, `count`, `watch_evt`, `status` and `irq_raw` are all zero.
- R2: Edge action codes are 0 = none, 1 = add one, 2 = subtract one, 3 = none. `pos_act` applies to rising edges and `neg_act` to falling edges, two bits per channel (channel c uses bits [2c+1:2c]). The control level picks `hi_act` (control high) or `lo_act` (control low). Level code 0 keeps the edge action, 1 swaps add and subtract, and 2 or 3 suppresses counting.
- R3: When both channels produce a step in the same cycle, the steps are summed, so the total moves by -2 to +2 in one update.
- R4: With `filt_en` high, a pin level held for fewer than `filt_thr` clock cycles is ignored, and a level held for at least `filt_thr` cycles is accepted. With `filt_en` low, every synchronised level passes.
- R5: With the filter off, a pulse edge applied just before clock edge k changes `count` after clock edge k+3.
- R6: While `pause` is high, the total holds and edges seen in that time are discarded. `clr` forces the total to zero and takes priority over everything else. Counting resumes from zero once `clr` falls.
- R7: Watch events are indexed 0 = match 1 (`thr1`), 1 = match 0 (`thr0`), 2 = lower limit, 3 = upper limit, 4 = zero crossing, and `evt_en[i]` enables event i. A counting step that reaches or passes an enabled limit pulses that event, and the total is zero one cycle later. The step input of that cycle is discarded.
- R8: An enabled match event pulses in the cycle after a counting step makes the total equal to its match value.
- R9: `status[1:0]` holds the last zero-crossing direction. The codes are 0 = positive to zero, 1 = negative to zero, 2 = negative to positive, 3 = positive to negative. The code is updated on every counting step that reaches or crosses zero, and an enabled event 4 pulses on such a step.
- R10: `status[6:2]` holds the event vector of the most recent cycle in which any event fired, bit 2+i for event i. `watch_evt` pulses that same vector for one cycle.
- R11: `irq_raw` is set by any event and stays set until a cycle with `int_clr` high and no new event. `irq` equals `irq_raw` gated by `int_ena`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | NCH | Pulse pin per channel |
| ctrl_in | input | NCH | Control pin per channel |
| pos_act | input | 2*NCH | Rising-edge action per channel |
| neg_act | input | 2*NCH | Falling-edge action per channel |
| hi_act | input | 2*NCH | Action modifier while control is high |
| lo_act | input | 2*NCH | Action modifier while control is low |
| filt_en | input | 1 | Glitch filter enable |
| filt_thr | input | FILT_W | Minimum accepted level width in cycles |
| pause | input | 1 | Freeze counting |
| clr | input | 1 | Force total to zero |
| lim_hi | input | CNT_W | Upper limit, signed |
| lim_lo | input | CNT_W | Lower limit, signed |
| thr0 | input | CNT_W | Match value for event 1, signed |
| thr1 | input | CNT_W | Match value for event 0, signed |
| evt_en | input | 5 | Per-event enables |
| int_ena | input | 1 | Interrupt enable |
| int_clr | input | 1 | Write-one-to-clear of the interrupt flag |
| count | output | CNT_W | Signed running total |
| watch_evt | output | 5 | One-cycle event pulses |
| status | output | 7 | Event vector [6:2] and zero-cross code [1:0] |
| irq_raw | output | 1 | Latched interrupt flag |
| irq | output | 1 | Enabled interrupt request |

## Verification
The bench builds the unit with its defaults: two channels, a 16-bit total and a 10-bit filter threshold. It sets the limits to +4 and -3 and the match values to +2 and -1, so both limit wraps, both match events and all four zero-crossing codes occur within a few dozen pulses. A filter threshold of five separates a three-cycle glitch from an eight-cycle level. A behavioural model steps the same pins each cycle and is compared with every output on every clock.

// File: rtl/qpc_pkg.sv
// Shared encodings for the quadrature pulse counter.
// Assumes: event indices are fixed and decoded by software in this order.
package qpc_pkg;
    localparam int EVT_N   = 5;
    localparam int EV_THR1 = 0;
    localparam int EV_THR0 = 1;
    localparam int EV_LOW  = 2;
    localparam int EV_HIGH = 3;
    localparam int EV_ZERO = 4;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_UP   = 2'd1,
        EDGE_DOWN = 2'd2,
        EDGE_RSVD = 2'd3
    } edge_act_e;

    typedef enum logic [1:0] {
        LVL_KEEP  = 2'd0,
        LVL_SWAP  = 2'd1,
        LVL_BLOCK = 2'd2,
        LVL_RSVD  = 2'd3
    } lvl_act_e;

    typedef enum logic [1:0] {
        ZC_POS_ZERO = 2'd0,
        ZC_NEG_ZERO = 2'd1,
        ZC_NEG_POS  = 2'd2,
        ZC_POS_NEG  = 2'd3
    } zc_mode_e;
endpackage

// File: rtl/qpc_input_cond.sv
// Input conditioning for one pin: a two-stage synchroniser followed by a
// width filter. When the filter is enabled, a new level is accepted only
// after it has been seen for filt_thr consecutive cycles. A threshold of 0
// behaves like 1.
// Assumes: din is asynchronous. filt_en and filt_thr are quasi-static.
module qpc_input_cond #(
    parameter int FILT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              filt_en,
    input  logic [FILT_W-1:0] filt_thr,
    output logic              dout
);
    localparam int RUN_W = FILT_W + 1;

    logic [1:0]        sync_q;
    logic              lvl_q;
    logic [FILT_W-1:0] run_q;
    logic [RUN_W-1:0]  run_inc;

    assign run_inc = {1'b0, run_q} + RUN_W'(1);
    assign dout    = lvl_q;

    // Two-flop synchroniser for the asynchronous pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[0], din};
    end

    // Width filter: count cycles that disagree with the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
        end else if (!filt_en) begin
            lvl_q <= sync_q[1];
            run_q <= '0;
        end else if (sync_q[1] == lvl_q) begin
            run_q <= '0;
        end else if (run_inc >= {1'b0, filt_thr}) begin
            lvl_q <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_inc[FILT_W-1:0];
        end
    end
endmodule

// File: rtl/qpc_chan_act.sv
// Per-channel action decoder. It detects edges on the filtered pulse,
// selects the edge action, applies the control-level modifier and yields a
// signed step of -1, 0 or +1.
// Assumes: pulse_f and ctrl_f are already synchronous and filtered.
module qpc_chan_act
    import qpc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_f,
    input  logic              ctrl_f,
    input  logic [1:0]        pos_act,
    input  logic [1:0]        neg_act,
    input  logic [1:0]        hi_act,
    input  logic [1:0]        lo_act,
    output logic signed [1:0] step
);
    logic      prev_q;
    logic      rise, fall;
    logic      base_up, base_dn, up, dn;
    edge_act_e act;
    lvl_act_e  lvl;

    // Previous filtered pulse level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pulse_f;
    end

    // Edge action selection, level modifier and step encoding.
    always_comb begin
        rise    = pulse_f & ~prev_q;
        fall    = ~pulse_f & prev_q;
        act     = rise ? edge_act_e'(pos_act) :
                  fall ? edge_act_e'(neg_act) : EDGE_NONE;
        base_up = (act == EDGE_UP);
        base_dn = (act == EDGE_DOWN);
        lvl     = ctrl_f ? lvl_act_e'(hi_act) : lvl_act_e'(lo_act);
        case (lvl)
            LVL_KEEP: begin up = base_up; dn = base_dn; end
            LVL_SWAP: begin up = base_dn; dn = base_up; end
            default:  begin up = 1'b0;    dn = 1'b0;    end
        endcase
        if (up)      step = 2'sb01;
        else if (dn) step = 2'sb11;
        else         step = 2'sb00;
    end
endmodule

// File: rtl/qpc_count_core.sv
// Signed total with limit wrap, match, zero-crossing and interrupt logic.
// Priority per cycle: clear, then a pending limit wrap, then pause, then the
// summed step.
// Assumes: lim_lo <= 0 <= lim_hi. step_sum is the sum of all channel steps.
module qpc_count_core
    import qpc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int STEP_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [STEP_W-1:0] step_sum,
    input  logic                    pause,
    input  logic                    clr,
    input  logic signed [CNT_W-1:0] lim_hi,
    input  logic signed [CNT_W-1:0] lim_lo,
    input  logic signed [CNT_W-1:0] thr0,
    input  logic signed [CNT_W-1:0] thr1,
    input  logic [EVT_N-1:0]        evt_en,
    input  logic                    int_clr,
    output logic [CNT_W-1:0]        count,
    output logic [EVT_N-1:0]        watch_evt,
    output logic [1:0]              zc_mode,
    output logic [EVT_N-1:0]        evt_seen,
    output logic                    irq_raw
);
    localparam int WIDE_W = CNT_W + STEP_W;
    localparam logic signed [CNT_W-1:0] ZERO = '0;

    logic signed [CNT_W-1:0]  cnt_q, cnt_d, nxt_n;
    logic signed [WIDE_W-1:0] cnt_ext, step_ext, hi_ext, lo_ext, nxt_w;
    logic                     wrap_q, wrap_d, step_ok, crossed;
    logic [EVT_N-1:0]         evt_c, evt_q, seen_q;
    zc_mode_e                 zc_q, zc_d;
    logic                     raw_q;

    assign cnt_ext  = {{STEP_W{cnt_q[CNT_W-1]}}, cnt_q};
    assign step_ext = {{CNT_W{step_sum[STEP_W-1]}}, step_sum};
    assign hi_ext   = {{STEP_W{lim_hi[CNT_W-1]}}, lim_hi};
    assign lo_ext   = {{STEP_W{lim_lo[CNT_W-1]}}, lim_lo};
    assign nxt_w    = cnt_ext + step_ext;
    assign nxt_n    = nxt_w[CNT_W-1:0];

    // Next total, events, wrap request and zero-cross code.
    always_comb begin
        step_ok = !clr && !wrap_q && !pause && (step_sum != '0);
        cnt_d   = cnt_q;
        wrap_d  = 1'b0;
        zc_d    = zc_q;
        evt_c   = '0;
        crossed = 1'b0;
        if (clr || wrap_q) begin
            cnt_d = ZERO;
        end else if (step_ok) begin
            cnt_d = nxt_n;
            if (evt_en[EV_THR0] && nxt_n == thr0) evt_c[EV_THR0] = 1'b1;
            if (evt_en[EV_THR1] && nxt_n == thr1) evt_c[EV_THR1] = 1'b1;
            if (evt_en[EV_HIGH] && nxt_w >= hi_ext && cnt_q < lim_hi)
                evt_c[EV_HIGH] = 1'b1;
            if (evt_en[EV_LOW] && nxt_w <= lo_ext && cnt_q > lim_lo)
                evt_c[EV_LOW] = 1'b1;
            if (cnt_q > ZERO && nxt_n == ZERO) begin
                zc_d = ZC_POS_ZERO; crossed = 1'b1;
            end else if (cnt_q < ZERO && nxt_n == ZERO) begin
                zc_d = ZC_NEG_ZERO; crossed = 1'b1;
            end else if (cnt_q < ZERO && nxt_n > ZERO) begin
                zc_d = ZC_NEG_POS; crossed = 1'b1;
            end else if (cnt_q > ZERO && nxt_n < ZERO) begin
                zc_d = ZC_POS_NEG; crossed = 1'b1;
            end
            if (evt_en[EV_ZERO] && crossed) evt_c[EV_ZERO] = 1'b1;
            wrap_d = evt_c[EV_HIGH] | evt_c[EV_LOW];
        end
    end

    // Total, wrap flag and zero-cross code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            wrap_q <= 1'b0;
            zc_q   <= ZC_POS_ZERO;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= wrap_d;
            zc_q   <= zc_d;
        end
    end

    // Event pulse, last-event record and interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q  <= '0;
            seen_q <= '0;
            raw_q  <= 1'b0;
        end else begin
            evt_q <= evt_c;
            if (|evt_c) seen_q <= evt_c;
            raw_q <= (raw_q & ~int_clr) | (|evt_c);
        end
    end

    assign count     = cnt_q;
    assign watch_evt = evt_q;
    assign zc_mode   = zc_q;
    assign evt_seen  = seen_q;
    assign irq_raw   = raw_q;
endmodule

// File: rtl/quad_pulse_counter.sv
// Top of the pulse counter unit. It instantiates one conditioner per pin,
// one action decoder per channel, sums the channel steps and feeds the
// count core.
// Assumes: all configuration inputs are quasi-static and synchronous to clk.
module quad_pulse_counter
    import qpc_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CNT_W  = 16,
    parameter int FILT_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      pulse_in,
    input  logic [NCH-1:0]      ctrl_in,
    input  logic [2*NCH-1:0]    pos_act,
    input  logic [2*NCH-1:0]    neg_act,
    input  logic [2*NCH-1:0]    hi_act,
    input  logic [2*NCH-1:0]    lo_act,
    input  logic                filt_en,
    input  logic [FILT_W-1:0]   filt_thr,
    input  logic                pause,
    input  logic                clr,
    input  logic [CNT_W-1:0]    lim_hi,
    input  logic [CNT_W-1:0]    lim_lo,
    input  logic [CNT_W-1:0]    thr0,
    input  logic [CNT_W-1:0]    thr1,
    input  logic [EVT_N-1:0]    evt_en,
    input  logic                int_ena,
    input  logic                int_clr,
    output logic [CNT_W-1:0]    count,
    output logic [EVT_N-1:0]    watch_evt,
    output logic [EVT_N+1:0]    status,
    output logic                irq_raw,
    output logic                irq
);
    localparam int STEP_W = $clog2(NCH + 1) + 1;

    logic [NCH-1:0]          pulse_f, ctrl_f;
    logic signed [1:0]       ch_step [NCH];
    logic signed [STEP_W-1:0] step_sum;
    logic [1:0]              zc_mode;
    logic [EVT_N-1:0]        evt_seen;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        qpc_input_cond #(.FILT_W(FILT_W)) u_pulse_cond (
            .clk(clk), .rst_n(rst_n), .din(pulse_in[c]),
            .filt_en(filt_en), .filt_thr(filt_thr), .dout(pulse_f[c])
        );
        qpc_input_cond #(.FILT_W(FILT_W)) u_ctrl_cond (
            .clk(clk), .rst_n(rst_n), .din(ctrl_in[c]),
            .filt_en(filt_en), .filt_thr(filt_thr), .dout(ctrl_f[c])
        );
        qpc_chan_act u_act (
            .clk(clk), .rst_n(rst_n),
            .pulse_f(pulse_f[c]), .ctrl_f(ctrl_f[c]),
            .pos_act(pos_act[2*c +: 2]), .neg_act(neg_act[2*c +: 2]),
            .hi_act(hi_act[2*c +: 2]),   .lo_act(lo_act[2*c +: 2]),
            .step(ch_step[c])
        );
    end

    // Sum the per-channel steps with sign extension.
    always_comb begin
        step_sum = '0;
        for (int c = 0; c < NCH; c++)
            step_sum = step_sum + {{(STEP_W-2){ch_step[c][1]}}, ch_step[c]};
    end

    qpc_count_core #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_core (
        .clk(clk), .rst_n(rst_n), .step_sum(step_sum),
        .pause(pause), .clr(clr),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .thr0(thr0), .thr1(thr1),
        .evt_en(evt_en), .int_clr(int_clr),
        .count(count), .watch_evt(watch_evt), .zc_mode(zc_mode),
        .evt_seen(evt_seen), .irq_raw(irq_raw)
    );

    assign status = {evt_seen, zc_mode};
    assign irq    = irq_raw & int_ena;
endmodule

// File: rtl/qpc_checker.sv
// Property checker for the pulse counter top, attached by bind.
// Assumes: default widths (16-bit total, 5 events, 7-bit status).
module qpc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        pause,
    input logic        clr,
    input logic        int_clr,
    input logic [15:0] count,
    input logic [4:0]  watch_evt,
    input logic [6:0]  status,
    input logic        irq_raw
);
    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> count == 16'd0);
    // R6
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !clr && !watch_evt[2] && !watch_evt[3]) |=> $stable(count));
    // R7
    limit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (watch_evt[2] || watch_evt[3]) |=> count == 16'd0);
    // R3
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !watch_evt[2] && !watch_evt[3]) |=>
        ($signed(16'(count - $past(count))) <= 16'sd2 &&
         $signed(16'(count - $past(count))) >= -16'sd2));
    // R10
    seen_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|watch_evt) |-> status[6:2] == watch_evt);
    // R11
    raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|watch_evt) |-> irq_raw);
    // R11
    raw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_raw && !int_clr) |=> irq_raw);
endmodule

bind quad_pulse_counter qpc_checker u_qpc_checker (
    .clk(clk), .rst_n(rst_n), .pause(pause), .clr(clr), .int_clr(int_clr),
    .count(count), .watch_evt(watch_evt), .status(status), .irq_raw(irq_raw)
);

// File: tb/quad_pulse_counter_bench.sv
// Bench: behavioural reference compared every clock plus targeted checks.
module quad_pulse_counter_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] pulse_in = '0, ctrl_in = '0;
    logic [3:0] pos_act = '0, neg_act = '0, hi_act = '0, lo_act = '0;
    logic filt_en = 1'b0;
    logic [9:0] filt_thr = '0;
    logic pause = 1'b0, clr = 1'b0;
    logic [15:0] lim_hi = 16'd100, lim_lo = 16'hFF9C, thr0 = '0, thr1 = '0;
    logic [4:0] evt_en = '0;
    logic int_ena = 1'b0, int_clr = 1'b0;
    logic [15:0] count;
    logic [4:0]  watch_evt;
    logic [6:0]  status;
    logic irq_raw, irq;

    int n_checks = 0, n_errors = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_pulse_counter u_quad_pulse_counter (
        .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .ctrl_in(ctrl_in),
        .pos_act(pos_act), .neg_act(neg_act), .hi_act(hi_act), .lo_act(lo_act),
        .filt_en(filt_en), .filt_thr(filt_thr), .pause(pause), .clr(clr),
        .lim_hi(lim_hi), .lim_lo(lim_lo), .thr0(thr0), .thr1(thr1),
        .evt_en(evt_en), .int_ena(int_ena), .int_clr(int_clr),
        .count(count), .watch_evt(watch_evt), .status(status),
        .irq_raw(irq_raw), .irq(irq)
    );

    // ---------------- reference model ----------------
    int m_s1[4], m_s2[4], m_f[4], m_run[4], m_prev[2];
    int m_cnt, m_zc;
    bit m_wrap, m_raw;
    logic [4:0] m_evt, m_seen;

    function automatic int to16(int v);
        logic [15:0] t;
        t = v[15:0];
        return $signed(t);
    endfunction

    always @(posedge clk) begin : ref_model
        int d, n, n16, a, lv, pin;
        int up, dn, tmp;
        bit crossed;
        logic [4:0] ev;
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_f[i] = 0; m_run[i] = 0;
            end
            m_prev[0] = 0; m_prev[1] = 0;
            m_cnt = 0; m_zc = 0; m_wrap = 0; m_raw = 0;
            m_evt = '0; m_seen = '0;
        end else begin
            d = 0;
            for (int ch = 0; ch < 2; ch++) begin
                if (m_f[ch] == 1 && m_prev[ch] == 0)      a = pos_act[2*ch +: 2];
                else if (m_f[ch] == 0 && m_prev[ch] == 1) a = neg_act[2*ch +: 2];
                else                                      a = 0;
                up = (a == 1) ? 1 : 0;
                dn = (a == 2) ? 1 : 0;
                lv = (m_f[2+ch] == 1) ? int'(hi_act[2*ch +: 2]) : int'(lo_act[2*ch +: 2]);
                if (lv == 1) begin tmp = up; up = dn; dn = tmp; end
                else if (lv >= 2) begin up = 0; dn = 0; end
                d = d + up - dn;
            end
            ev = '0;
            if (clr || m_wrap) begin
                m_cnt = 0; m_wrap = 0;
            end else if (!pause && d != 0) begin
                n = m_cnt + d;
                n16 = to16(n);
                crossed = 0;
                if (evt_en[1] && n16 == $signed(thr0)) ev[1] = 1'b1;
                if (evt_en[0] && n16 == $signed(thr1)) ev[0] = 1'b1;
                if (evt_en[3] && n >= $signed(lim_hi) && m_cnt < $signed(lim_hi)) ev[3] = 1'b1;
                if (evt_en[2] && n <= $signed(lim_lo) && m_cnt > $signed(lim_lo)) ev[2] = 1'b1;
                if (m_cnt > 0 && n16 == 0)      begin m_zc = 0; crossed = 1; end
                else if (m_cnt < 0 && n16 == 0) begin m_zc = 1; crossed = 1; end
                else if (m_cnt < 0 && n16 > 0)  begin m_zc = 2; crossed = 1; end
                else if (m_cnt > 0 && n16 < 0)  begin m_zc = 3; crossed = 1; end
                if (crossed && evt_en[4]) ev[4] = 1'b1;
                m_cnt = n16;
                m_wrap = ev[3] | ev[2];
            end
            m_raw = (m_raw && !int_clr) || (ev != 0);
            if (ev != 0) m_seen = ev;
            m_evt = ev;
            m_prev[0] = m_f[0]; m_prev[1] = m_f[1];
            for (int i = 0; i < 4; i++) begin
                pin = (i < 2) ? int'(pulse_in[i]) : int'(ctrl_in[i-2]);
                if (!filt_en) begin
                    m_f[i] = m_s2[i]; m_run[i] = 0;
                end else if (m_s2[i] == m_f[i]) begin
                    m_run[i] = 0;
                end else if (m_run[i] + 1 >= int'(filt_thr)) begin
                    m_f[i] = m_s2[i]; m_run[i] = 0;
                end else begin
                    m_run[i] = m_run[i] + 1;
                end
                m_s2[i] = m_s1[i];
                m_s1[i] = pin;
            end
        end
    end

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (count !== 16'(m_cnt) || watch_evt !== m_evt ||
                status !== {m_seen, 2'(m_zc)} || irq_raw !== m_raw ||
                irq !== (m_raw & int_ena)) begin
                n_errors++;
                $display("FAIL %s model: count=%0d/%0d evt=%b/%b status=%b/%b raw=%b/%b irq=%b/%b",
                         cur_req, $signed(count), m_cnt, watch_evt, m_evt,
                         status, {m_seen, 2'(m_zc)}, irq_raw, m_raw,
                         irq, m_raw & int_ena);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic settle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(logic [1:0] which, int w);
        @(negedge clk) pulse_in = which;
        settle(w);
        pulse_in = 2'b00;
        settle(w);
    endtask

    function automatic int cnt_s();
        return $signed(count);
    endfunction

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        int base;
        settle(4);
        @(negedge clk) rst_n = 1'b1;
        settle(2);
        // R1 reset state
        check_eq("R1", "count", cnt_s(), 0);
        check_eq("R1", "status", int'(status), 0);
        check_eq("R1", "irq_raw", int'(irq_raw), 0);

        // R2 edge and level actions on channel 0
        cur_req = "R2";
        pos_act = 4'b00_01;
        repeat (3) pulse(2'b01, 2);
        settle(6);
        check_eq("R2", "keep increments", cnt_s(), 3);
        lo_act = 4'b00_01;
        repeat (2) pulse(2'b01, 2);
        settle(6);
        check_eq("R2", "swap decrements", cnt_s(), 1);
        lo_act = 4'b00_10;
        repeat (2) pulse(2'b01, 2);
        settle(6);
        check_eq("R2", "block ignores edges", cnt_s(), 1);
        lo_act = 4'b00_00;
        neg_act = 4'b00_10;
        pulse(2'b01, 3);
        settle(6);
        check_eq("R2", "rise up fall down", cnt_s(), 1);
        neg_act = 4'b00_00;
        hi_act = 4'b00_01;
        @(negedge clk) ctrl_in = 2'b01;
        settle(8);
        pulse(2'b01, 2);
        settle(6);
        check_eq("R2", "control high swap", cnt_s(), 0);
        @(negedge clk) ctrl_in = 2'b00;
        settle(8);

        // R5 latency with filter off
        cur_req = "R5";
        base = cnt_s();
        @(negedge clk) pulse_in = 2'b01;
        settle(3);
        check_eq("R5", "no change before fourth edge", cnt_s(), base);
        settle(1);
        check_eq("R5", "change after fourth edge", cnt_s(), base + 1);
        @(negedge clk) pulse_in = 2'b00;
        settle(6);

        // R3 both channels in one cycle
        cur_req = "R3";
        pos_act = 4'b01_01;
        base = cnt_s();
        pulse(2'b11, 3);
        settle(6);
        check_eq("R3", "two increments summed", cnt_s(), base + 2);
        pos_act = 4'b10_01;
        pulse(2'b11, 3);
        settle(6);
        check_eq("R3", "increment plus decrement", cnt_s(), base + 2);
        pos_act = 4'b00_01;

        // R4 glitch filter
        cur_req = "R4";
        filt_en = 1'b1;
        filt_thr = 10'd5;
        settle(4);
        base = cnt_s();
        pulse(2'b01, 3);
        settle(12);
        check_eq("R4", "short level ignored", cnt_s(), base);
        pulse(2'b01, 8);
        settle(12);
        check_eq("R4", "long level accepted", cnt_s(), base + 1);
        filt_en = 1'b0;
        settle(4);

        // R6 pause and clear
        cur_req = "R6";
        base = cnt_s();
        @(negedge clk) pause = 1'b1;
        repeat (2) pulse(2'b01, 2);
        settle(6);
        check_eq("R6", "paused total held", cnt_s(), base);
        @(negedge clk) pause = 1'b0;
        settle(2);
        check_eq("R6", "no late count after pause", cnt_s(), base);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
        check_eq("R6", "clear to zero", cnt_s(), 0);
        pulse(2'b01, 2);
        settle(6);
        check_eq("R6", "resume from zero", cnt_s(), 1);
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;

        // R7 limits
        cur_req = "R7";
        lim_hi = 16'd4;
        lim_lo = 16'hFFFD;
        evt_en = 5'b01000;
        repeat (4) pulse(2'b01, 2);
        settle(6);
        check_eq("R7", "upper limit wraps", cnt_s(), 0);
        check_eq("R7", "upper limit recorded", int'(status[6:2]), 5'b01000);
        evt_en = 5'b00100;
        lo_act = 4'b00_01;
        repeat (3) pulse(2'b01, 2);
        settle(6);
        check_eq("R7", "lower limit wraps", cnt_s(), 0);
        check_eq("R7", "lower limit recorded", int'(status[6:2]), 5'b00100);

        // R8 match values
        cur_req = "R8";
        thr0 = 16'd2;
        thr1 = 16'hFFFF;
        evt_en = 5'b01111;
        lo_act = 4'b00_00;
        repeat (2) pulse(2'b01, 2);
        settle(6);
        check_eq("R8", "count at match", cnt_s(), 2);
        check_eq("R8", "match 0 event", int'(status[6:2]), 5'b00010);

        // R9 zero crossing codes, R10 status layout
        cur_req = "R9";
        evt_en = 5'b11111;
        lo_act = 4'b00_01;
        repeat (2) pulse(2'b01, 2);
        settle(6);
        check_eq("R9", "positive to zero", int'(status), 7'b1000000);
        pulse(2'b01, 2);
        settle(6);
        check_eq("R10", "match 1 only, code kept", int'(status), 7'b0000100);
        lo_act = 4'b00_00;
        pulse(2'b01, 2);
        settle(6);
        check_eq("R9", "negative to zero", int'(status), 7'b1000001);
        lo_act = 4'b00_01;
        pulse(2'b01, 2);
        settle(6);
        check_eq("R9", "back to minus one", cnt_s(), -1);
        lo_act = 4'b00_00;
        pos_act = 4'b01_01;
        pulse(2'b11, 3);
        settle(6);
        check_eq("R9", "negative to positive", int'(status), 7'b1000010);
        lo_act = 4'b01_01;
        pulse(2'b11, 3);
        settle(6);
        check_eq("R9", "positive to negative", int'(status), 7'b1000111);
        check_eq("R9", "count after crossing", cnt_s(), -1);

        // R11 interrupt
        cur_req = "R11";
        int_ena = 1'b0;
        settle(1);
        check_eq("R11", "raw set", int'(irq_raw), 1);
        check_eq("R11", "irq masked", int'(irq), 0);
        int_ena = 1'b1;
        settle(1);
        check_eq("R11", "irq enabled", int'(irq), 1);
        @(negedge clk) int_clr = 1'b1;
        @(negedge clk) int_clr = 1'b0;
        check_eq("R11", "raw cleared", int'(irq_raw), 0);
        check_eq("R11", "irq cleared", int'(irq), 0);

        settle(4);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule